// File: doc/BRIEF.md
# Integrating push-button debouncer with press events

This block cleans up a small group of active-low mechanical push-buttons. It has one clock, taken from a stable on-board oscillator, and no logic runs on an edge of a key line. Every key goes through a two-flop synchroniser. It then drives its own saturating up/down counter. The counter climbs one step on each cycle that the key reads high (released) and falls one step on each cycle that it reads low (pressed). Its travel runs from zero to a top value worth a few milliseconds of clock time.

A press is accepted only when the counter hits zero. The block then reports a debounced "pressed" level and a single-cycle press pulse for that key. The key is treated as released, and a new press is armed, only when the counter climbs all the way back to its top value. Contact bounce moves the counter through intermediate counts, and these never change an output. Each key has its own independent lane, so presses on different keys in the same cycle each give their own pulse. Nothing here decides what the pulses drive.

Top module: `key_debounce`

## Requirements
- R1: While rst_ni is low, every pressed_o bit and every press_o bit is 0.
- R2: Each key_ni bit passes through two synchroniser flops, so a clean low step on a released key raises press_o exactly TOP+3 rising edges after the step, where TOP = CLK_HZ/1_000_000 * DEBOUNCE_US (default 5000 us).
- R3: Each key's counter rises by one per cycle while its synchronised input is 1 and falls by one while it is 0. It holds at 0 and at TOP, never wraps, and never moves by more than one per cycle.
- R4: A low burst that drives the counter down but not to 0 leaves pressed_o and press_o unchanged.
- R5: press_o of a key is high for exactly one cycle per accepted press. It rises together with pressed_o, on the edge after the counter is seen at 0 while the key is in the released state.
- R6: After a press, no further press is accepted until the counter has reached TOP. A release burst that stops short of TOP and is followed by another low period gives no second pulse.
- R7: pressed_o falls on the edge after the counter is seen at TOP, which is TOP+3 edges after a clean high step from a fully pressed key.
- R8: Reset loads every counter with TOP and every key state with released. A key held low through reset gives one pulse after reset ends, when its counter first reaches 0. After that pulse it gives no more until it has been fully released.
- R9: The lanes are independent. Simultaneous presses on several keys give simultaneous pulses, with no priority between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_ni | input | NUM_KEYS | Raw key lines, low = pressed |
| pressed_o | output | NUM_KEYS | Debounced level, 1 = pressed |
| press_o | output | NUM_KEYS | One-cycle pulse per accepted press |

## Verification
The bench builds the block with two keys, CLK_HZ of 1 MHz and DEBOUNCE_US of 8, which gives a top count of 8 in a 4-bit counter. With this count, full travel in both directions, saturation at each end and bursts stopping one short of either end all happen within tens of cycles. Random hold lengths between 1 and twice the top count then cover both full swings and partial bounces on both keys at once, and the exact press and release latencies can be counted edge by edge.

// File: rtl/key_debounce_pkg.sv
package key_debounce_pkg;

  typedef enum logic {
    KEY_UP   = 1'b0,
    KEY_DOWN = 1'b1
  } key_state_e;

  function automatic int unsigned top_count(int unsigned clk_hz, int unsigned settle_us);
    int unsigned t;
    t = (clk_hz / 1_000_000) * settle_us;
    return (t == 0) ? 1 : t;
  endfunction

endpackage

// File: rtl/key_sync.sv
module key_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {STAGES{RST_VAL}};
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];

endmodule

// File: rtl/key_integrator.sv
module key_integrator #(
  parameter int unsigned TOP   = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             level_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_bot_o,
  output logic             at_top_o
);

  localparam logic [CNT_W-1:0] TopVal = CNT_W'(TOP);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (level_i && cnt_q != TopVal)        cnt_d = cnt_q + 1'b1;
    else if (!level_i && cnt_q != '0)      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= TopVal;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign at_bot_o = (cnt_q == '0);
  assign at_top_o = (cnt_q == TopVal);

endmodule

// File: rtl/key_event.sv
module key_event
  import key_debounce_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic at_bot_i,
  input  logic at_top_i,
  output logic pressed_o,
  output logic press_o
);

  key_state_e state_q, state_d;
  logic       pulse_q, pulse_d;

  always_comb begin
    state_d = state_q;
    pulse_d = 1'b0;
    unique case (state_q)
      KEY_UP: if (at_bot_i) begin
        state_d = KEY_DOWN;
        pulse_d = 1'b1;
      end
      KEY_DOWN: if (at_top_i) state_d = KEY_UP;
      default: state_d = KEY_UP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KEY_UP;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  assign pressed_o = (state_q == KEY_DOWN);
  assign press_o   = pulse_q;

endmodule

// File: rtl/key_debounce_ch.sv
module key_debounce_ch #(
  parameter int unsigned TOP   = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_ni,
  output logic pressed_o,
  output logic press_o
);

  logic             key_s;
  logic [CNT_W-1:0] cnt;
  logic             at_bot, at_top;

  key_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (key_ni),
    .q_o   (key_s)
  );

  key_integrator #(.TOP(TOP), .CNT_W(CNT_W)) u_int (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (key_s),
    .cnt_o   (cnt),
    .at_bot_o(at_bot),
    .at_top_o(at_top)
  );

  key_event u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .at_bot_i (at_bot),
    .at_top_i (at_top),
    .pressed_o(pressed_o),
    .press_o  (press_o)
  );

endmodule

// File: rtl/key_debounce.sv
module key_debounce #(
  parameter int unsigned NUM_KEYS    = 2,
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned DEBOUNCE_US = 5000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_KEYS-1:0] key_ni,
  output logic [NUM_KEYS-1:0] pressed_o,
  output logic [NUM_KEYS-1:0] press_o
);

  localparam int unsigned Top  = key_debounce_pkg::top_count(CLK_HZ, DEBOUNCE_US);
  localparam int unsigned CntW = $clog2(Top + 1);

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    key_debounce_ch #(.TOP(Top), .CNT_W(CntW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .key_ni   (key_ni[k]),
      .pressed_o(pressed_o[k]),
      .press_o  (press_o[k])
    );
  end

endmodule

// File: rtl/key_debounce_chk.sv
module key_debounce_chk #(
  parameter int unsigned TOP   = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt,
  input logic             pressed,
  input logic             press
);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(TOP)); // R3

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || ($past(cnt) == cnt + 1'b1)); // R3

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press |=> !press); // R5

  AST_PULSE_WITH_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press |-> (pressed && !$past(pressed))); // R5

  AST_PRESS_AT_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pressed) |-> ($past(cnt) == '0)); // R5

  AST_RELEASE_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pressed) |-> ($past(cnt) == CNT_W'(TOP))); // R7

  always_comb begin
    if (!rst_ni) AST_RESET_QUIET: assert (!pressed && !press); // R1
  end

endmodule

bind key_debounce_ch key_debounce_chk #(.TOP(TOP), .CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cnt    (cnt),
  .pressed(pressed_o),
  .press  (press_o)
);

// File: tb/key_debounce_tb.sv
module key_debounce_tb;
  localparam int N = 2;
  localparam int CLK_HZ = 1_000_000;
  localparam int US = 8;
  localparam int TOP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] key_n = '1;
  logic [N-1:0] pressed, press;

  int tests = 0, fails = 0;
  int acc [N];
  string cur_req = "R1";

  // reference model state
  logic [N-1:0] m_s1, m_s2, m_prs, m_pls;
  int m_cnt [N];

  always #5 clk = ~clk;

  key_debounce #(.NUM_KEYS(N), .CLK_HZ(CLK_HZ), .DEBOUNCE_US(US)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .key_ni(key_n), .pressed_o(pressed), .press_o(press)
  );

  function automatic int next_cnt(int c, logic lvl);
    if (lvl && c < TOP) return c + 1;
    if (!lvl && c > 0)  return c - 1;
    return c;
  endfunction

  function automatic logic next_prs(logic p, int c);
    return p ? (c != TOP) : (c == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '1; m_s2 <= '1; m_prs <= '0; m_pls <= '0;
      for (int k = 0; k < N; k++) m_cnt[k] <= TOP;
    end else begin
      m_s1 <= key_n;
      m_s2 <= m_s1;
      for (int k = 0; k < N; k++) begin
        m_cnt[k] <= next_cnt(m_cnt[k], m_s2[k]);
        m_pls[k] <= (m_cnt[k] == 0) && !m_prs[k];
        m_prs[k] <= next_prs(m_prs[k], m_cnt[k]);
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clr();
    for (int k = 0; k < N; k++) acc[k] = 0;
  endtask

  // one cycle: sample at negedge, compare with model, accumulate pulses
  task automatic step();
    @(negedge clk);
    chk(pressed === m_prs, cur_req, int'(pressed), int'(m_prs));
    chk(press === m_pls, cur_req, int'(press), int'(m_pls));
    for (int k = 0; k < N; k++) if (press[k]) acc[k]++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // count edges until the watched output on key k matches val
  task automatic latency(int k, bit use_pulse, logic val, output int n);
    n = 0;
    for (int i = 1; i <= 4 * TOP; i++) begin
      step();
      if ((use_pulse ? press[k] : pressed[k]) === val) begin n = i; break; end
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    // R1 / R8: key 1 held through reset
    key_n = 2'b01;
    cur_req = "R1";
    run(3);
    chk(pressed === '0 && press === '0, "R1", int'({pressed, press}), 0);
    rst_n = 1'b1;
    cur_req = "R8";
    clr();
    run(3 * TOP);
    chk(acc[1] == 1, "R8 single pulse from held key", acc[1], 1);
    chk(acc[0] == 0, "R8 idle key quiet", acc[0], 0);
    clr();
    run(3 * TOP);
    chk(acc[1] == 0, "R8 no repeat while held", acc[1], 0);
    key_n = 2'b11;
    run(2 * TOP);
    key_n = 2'b01;
    clr();
    run(2 * TOP);
    chk(acc[1] == 1, "R8 press after release", acc[1], 1);
    key_n = 2'b11;
    run(2 * TOP);

    // R2: press latency
    cur_req = "R2";
    key_n[0] = 1'b0;
    latency(0, 1'b1, 1'b1, n);
    chk(n == TOP + 3, "R2 press latency", n, TOP + 3);
    run(2);
    // R7: release latency
    cur_req = "R7";
    key_n[0] = 1'b1;
    latency(0, 1'b0, 1'b0, n);
    chk(n == TOP + 3, "R7 release latency", n, TOP + 3);
    run(TOP);

    // R4: bounce stops one short of bottom
    cur_req = "R4";
    clr();
    key_n[0] = 1'b0;
    run(TOP - 1);
    key_n[0] = 1'b1;
    run(2 * TOP);
    chk(acc[0] == 0, "R4 partial low burst", acc[0], 0);
    chk(pressed[0] == 1'b0, "R4 level unchanged", int'(pressed[0]), 0);

    // R6: partial release does not re-arm
    cur_req = "R6";
    clr();
    key_n[0] = 1'b0;
    run(2 * TOP);
    key_n[0] = 1'b1;
    run(TOP - 1);
    key_n[0] = 1'b0;
    run(2 * TOP);
    chk(acc[0] == 1, "R6 no re-arm before top", acc[0], 1);
    chk(pressed[0] == 1'b1, "R6 level held", int'(pressed[0]), 1);
    key_n[0] = 1'b1;
    run(2 * TOP);
    key_n[0] = 1'b0;
    run(2 * TOP);
    chk(acc[0] == 2, "R6 re-arm after full release", acc[0], 2);
    key_n[0] = 1'b1;
    run(2 * TOP);

    // R9: simultaneous presses
    cur_req = "R9";
    key_n = 2'b00;
    run(TOP + 2);
    step();
    chk(press == 2'b11, "R9 both pulse together", int'(press), 3);
    run(2);
    key_n = 2'b11;
    run(2 * TOP);

    // R3 / R5: random hold lengths, compared against model every cycle
    cur_req = "R3/R5";
    begin
      int hold [N];
      void'($urandom(32'h5eed));
      for (int k = 0; k < N; k++) hold[k] = 1;
      for (int c = 0; c < 4000; c++) begin
        for (int k = 0; k < N; k++) begin
          hold[k]--;
          if (hold[k] == 0) begin
            key_n[k] = ~key_n[k];
            hold[k] = 1 + int'($urandom_range(2 * TOP - 1));
          end
        end
        step();
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule